// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block is a timer peripheral reached through an APB slave port. It carries two channels that run independently of each other. In each channel an 8-bit divider turns the timer clock into a slower tick stream, a 16-bit counter climbs by one on every tick, and a 16-bit compare value sets how many ticks make up one period. When a period ends, the channel latches a sticky status bit. If its interrupt enable is set, it also drives its own interrupt line.

Each channel runs in one of two modes. In the repeating mode the counter drops back to zero when a period ends and keeps running. In the one-shot mode the counter freezes at the compare value and the channel turns itself off by clearing its own run bit. Software restarts a channel by setting the run bit again. Software sets a channel up through four word registers: control, divider, compare and a read-only live count. A common status word at the end of the map lets software read and clear both sticky bits.

Top module: `itmr_top`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and both interrupt lines are low.
- R2: A divider field value N makes the channel tick once every N+1 timer clocks, and the counter rises by one on each tick. Setting the run bit while it is clear restarts both the divider and the counter from zero. While the run bit is clear, the counter holds its value.
- R3: A period ends on a tick that finds the counter equal to the compare value. One period therefore lasts (compare+1)*(N+1) clocks after the run bit is set. A compare value of zero ends a period on every tick.
- R4: In repeating mode (control bit1 = 0), the end of a period sets the status bit, returns the counter to zero and leaves the channel running.
- R5: In one-shot mode (control bit1 = 1), the end of a period sets the status bit, holds the counter at the compare value and clears the run bit (control bit0). This clearing wins over a control write in the same cycle.
- R6: The status word at offset 0x20 holds channel 0 in bit0 and channel 1 in bit1. A bit stays set until software writes 1 to it. Writing 0 leaves it unchanged. A period end in the same cycle as the clear keeps the bit set.
- R7: Interrupt line i is high exactly while status bit i and the interrupt-enable bit (control bit2) of channel i are both set.
- R8: Channel i occupies offsets 0x10*i + {0x0 control, 0x4 divider in bits 7:0, 0x8 compare in bits 15:0, 0xC count in bits 15:0}. A write happens in the APB access phase, and read data is valid during the access phase.
- R9: The count register is read-only, and writes to it have no effect.
- R10: Activity on one channel does not change the registers, status bit or interrupt line of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 6 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq | output | 2 | Per-channel interrupt lines |

## Verification
The embedded properties check, on every cycle, the following rules:
- the one-step counter advance on each tick;
- the return to zero in repeating mode;
- the frozen count and self-clearing run bit in one-shot mode;
- the frozen count of an idle channel;
- the spacing of divider ticks;
- the rule that a status bit rises only after a period end and falls after a write-one clear.

The exact period length for different divider and compare values, the order of the register map, the read-only count, channel isolation and interrupt gating can only be shown by the bench's timed scenarios, which count clocks from the enabling write to the interrupt edge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_DIV  = 2'd1,
        RG_CMP  = 2'd2,
        RG_CNT  = 2'd3
    } reg_sel_e;

    // bit2 interrupt enable, bit1 one-shot, bit0 run
    typedef struct packed {
        logic ie;
        logic one_shot;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_div;
        logic wr_cmp;
    } chan_wr_t;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        return ctrl_t'(w[2:0]);
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        return {29'd0, c};
    endfunction

endpackage

// File: rtl/itmr_presc.sv
module itmr_presc #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] acc;

    assign tick = run && (acc == div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) acc <= '0;
        else                     acc <= acc + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick && (div != '0) |=> (!tick || (div != $past(div)))); // R2

endmodule

// File: rtl/itmr_chan.sv
module itmr_chan
    import itmr_pkg::*;
#(
    parameter int PW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_wr_t      wr,
    input  logic [31:0]   wdata,
    output ctrl_t         ctrl,
    output logic [PW-1:0] div,
    output logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt,
    output logic          period_end
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    logic [PW-1:0] div_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cnt_q;
    logic          tick;
    logic          start;
    logic          unused_hi;

    assign unused_hi = ^wdata[31:CW];
    assign ctrl_new  = ctrl_unpack(wdata);
    assign start     = wr.wr_ctrl && ctrl_new.run && !ctrl_q.run;

    itmr_presc #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .div  (div_q),
        .tick (tick)
    );

    assign period_end = tick && (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            cmp_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr.wr_div) div_q  <= wdata[PW-1:0];
            if (wr.wr_cmp) cmp_q  <= wdata[CW-1:0];
            if (wr.wr_ctrl) ctrl_q <= ctrl_new;
            if (period_end && ctrl_q.one_shot) ctrl_q.run <= 1'b0;

            if (start)                              cnt_q <= '0;
            else if (period_end && !ctrl_q.one_shot) cnt_q <= '0;
            else if (tick && !period_end)           cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ctrl = ctrl_q;
    assign div  = div_q;
    assign cmp  = cmp_q;
    assign cnt  = cnt_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        tick && !period_end |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run && !start |=> $stable(cnt_q)); // R2
    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        period_end && !ctrl_q.one_shot |=> cnt_q == '0); // R4
    AST_SHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
        period_end && ctrl_q.one_shot |=> !ctrl_q.run); // R5
    AST_SHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        period_end && ctrl_q.one_shot |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int PW  = 8,
    parameter int CW  = 16,
    parameter int AW  = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           psel,
    input  logic           penable,
    input  logic           pwrite,
    input  logic [AW-1:0]  paddr,
    input  logic [31:0]    pwdata,
    output logic [31:0]    prdata,
    output logic [NCH-1:0] irq
);
    localparam int SW       = AW - 4;
    localparam int STAT_OFS = NCH * 16;

    logic           wr_en;
    logic [SW-1:0]  slot;
    reg_sel_e       rsel;
    logic           hit_stat;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] stat_q;
    logic           unused_lsb;

    ctrl_t         ctrl_a [NCH];
    logic [PW-1:0] div_a  [NCH];
    logic [CW-1:0] cmp_a  [NCH];
    logic [CW-1:0] cnt_a  [NCH];

    assign unused_lsb = ^paddr[1:0];
    assign wr_en      = psel && penable && pwrite;
    assign slot       = paddr[AW-1:4];
    assign rsel       = reg_sel_e'(paddr[3:2]);
    assign hit_stat   = (paddr == AW'(STAT_OFS));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chan_wr_t wr;
        logic     hit;

        assign hit        = wr_en && !hit_stat && (slot == SW'(ch));
        assign wr.wr_ctrl = hit && (rsel == RG_CTRL);
        assign wr.wr_div  = hit && (rsel == RG_DIV);
        assign wr.wr_cmp  = hit && (rsel == RG_CMP);

        itmr_chan #(.PW(PW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr         (wr),
            .wdata      (pwdata),
            .ctrl       (ctrl_a[ch]),
            .div        (div_a[ch]),
            .cmp        (cmp_a[ch]),
            .cnt        (cnt_a[ch]),
            .period_end (pend[ch])
        );

        assign irq[ch] = stat_q[ch] && ctrl_a[ch].ie;

        AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (rst)
            $rose(stat_q[ch]) |-> $past(pend[ch])); // R6
        AST_W1C: assert property (@(posedge clk) disable iff (rst)
            wr_en && hit_stat && pwdata[ch] && !pend[ch] |=> !stat_q[ch]); // R6
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (pend[i])                             stat_q[i] <= 1'b1;
                else if (wr_en && hit_stat && pwdata[i]) stat_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        prdata = '0;
        if (hit_stat) begin
            prdata[NCH-1:0] = stat_q;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (slot == SW'(i)) begin
                    case (rsel)
                        RG_CTRL: prdata = ctrl_pack(ctrl_a[i]);
                        RG_DIV:  prdata = 32'(div_a[i]);
                        RG_CMP:  prdata = 32'(cmp_a[i]);
                        default: prdata = 32'(cnt_a[i]);
                    endcase
                end
            end
        end
    end

endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    itmr_top dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    // div[40:33] cmp[32:17] one_shot[16] clocks-to-interrupt[15:0]
    localparam logic [40:0] VEC [7] = '{
        {8'd0,   16'd0, 1'b0, 16'd1},
        {8'd0,   16'd5, 1'b0, 16'd6},
        {8'd3,   16'd2, 1'b1, 16'd12},
        {8'd255, 16'd1, 1'b0, 16'd512},
        {8'd7,   16'd0, 1'b1, 16'd8},
        {8'd2,   16'd9, 1'b1, 16'd30},
        {8'd1,   16'd3, 1'b0, 16'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        d = prdata;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] keep;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        apb_read(6'h00, rd); check("R1 ctrl0", rd, 32'd0);
        apb_read(6'h10, rd); check("R1 ctrl1", rd, 32'd0);
        apb_read(6'h20, rd); check("R1 status", rd, 32'd0);
        apb_read(6'h0C, rd); check("R1 cnt0", rd, 32'd0);

        // vector table on channel 0: R3 period, R4 repeat, R5 one-shot
        for (int v = 0; v < 7; v++) begin
            logic [7:0]  dv;
            logic [15:0] cp;
            logic        os;
            logic [15:0] cyc;
            {dv, cp, os, cyc} = VEC[v];
            apb_write(6'h00, 32'd0);
            apb_write(6'h20, 32'd1);
            apb_write(6'h04, 32'(dv));
            apb_write(6'h08, 32'(cp));
            apb_write(6'h00, {29'd0, 1'b1, os, 1'b1});
            edges(int'(cyc) - 1);
            check("R3 irq before period end", 32'(irq[0]), 32'd0);
            edges(1);
            check("R3 irq at period end", 32'(irq[0]), 32'd1);
            apb_read(6'h0C, rd);
            if (os) check("R5 count held at compare", rd, 32'(cp));
            else    check("R4 count restarted", rd, (dv == 0 && cp != 0) ? 32'd1 : 32'd0);
            apb_read(6'h00, rd);
            check(os ? "R5 run bit cleared" : "R4 run bit kept", rd, os ? 32'd6 : 32'd5);
            apb_read(6'h20, rd);
            check("R6 status bit0 set", rd, 32'd1);
        end

        // R9 count is read-only; R8 register offsets
        apb_write(6'h00, 32'd0);
        apb_read(6'h0C, keep);
        apb_write(6'h0C, 32'h0000ABCD);
        apb_read(6'h0C, rd); check("R9 count write ignored", rd, keep);
        apb_read(6'h04, rd); check("R8 divider offset", rd, 32'd1);
        apb_read(6'h08, rd); check("R8 compare offset", rd, 32'd3);
        apb_write(6'h20, 32'd1);

        // R10 channel 1 alone, R7 interrupt gating
        apb_write(6'h14, 32'd1);
        apb_write(6'h18, 32'd2);
        apb_write(6'h10, 32'd1);
        edges(8);
        check("R7 irq masked without enable", 32'(irq), 32'd0);
        apb_read(6'h20, rd); check("R10 only channel 1 status", rd, 32'd2);
        apb_read(6'h00, rd); check("R10 channel 0 ctrl untouched", rd, 32'd0);
        apb_write(6'h10, 32'd5);
        check("R7 irq follows enable", 32'(irq), 32'd2);

        // R6 write-one-to-clear
        apb_write(6'h10, 32'd0);
        check("R7 irq drops with enable", 32'(irq), 32'd0);
        apb_write(6'h20, 32'd0);
        apb_read(6'h20, rd); check("R6 write 0 keeps status", rd, 32'd2);
        apb_write(6'h20, 32'd2);
        apb_read(6'h20, rd); check("R6 write 1 clears status", rd, 32'd0);

        // R4 repeating periods keep coming
        apb_write(6'h04, 32'd0);
        apb_write(6'h08, 32'd3);
        apb_write(6'h00, 32'd5);
        edges(3);
        check("R3 no irq mid period", 32'(irq), 32'd0);
        edges(1);
        check("R3 irq after 4 clocks", 32'(irq), 32'd1);
        apb_write(6'h20, 32'd1);
        edges(1);
        check("R6 cleared between periods", 32'(irq), 32'd0);
        edges(1);
        check("R4 second period end", 32'(irq), 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule